// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the pending state of one bank of interrupt sources for a virtual interrupt controller. Each source is set up as edge-triggered or level-triggered. Hardware lines report level changes through an indexed update port. Software sets or clears pending bits through two mask-style write ports and reads the pending vector back. The CPU side reports when it takes an interrupt into a delivery slot, and later when it completes that interrupt.

Software-forced pending and the physical line level are held in separate bits. A level source therefore stays pending for as long as either cause is present, and no longer. A level source that has been taken by a CPU is marked queued. It is not offered again until its completion arrives, or until its enable is removed. An edge source gives up its pending bit at the moment it is taken. When the block sits in bank 0, the lowest 16 sources are software-generated: the mask writes do not touch them.

Every state change is registered. All outputs, including the deliverable vector, change on the clock edge that follows the input cycle.

Top module: `irq_pend_tracker`

## Requirements
- R1: While rst is high, on each clock edge the pending readback, the deliverable vector, any_pend and eoi_err all become 0, and every internal queued, soft and level bit is cleared.
- R2: A line update to a level source (cfg_edge bit 0) acts only when the new level differs from the stored level. A rise sets the source pending. A fall clears pending only if the source has no software-forced pending.
- R3: A line update to an edge source (cfg_edge bit 1) sets pending only when the new level is 1 and the source is not already pending. A level of 0 has no effect.
- R4: A set-pending write makes every source under a 1 bit pending. For level sources it also records software-forced pending, so a later line fall does not clear the pending bit.
- R5: A clear-pending write clears both pending and software-forced pending for every source under a 1 bit. A level source whose line is still high stays pending.
- R6: With BANK_SEL = 0, sources 0 to 15 ignore set-pending and clear-pending writes. They still respond to line updates.
- R7: An accept (q_valid with q_idx) acts only on a source that is deliverable. An edge source loses its pending bit at once. A level source is marked queued and is not deliverable until it completes.
- R8: An end-of-interrupt for a level source clears its queued and software-forced bits. If the line is still high, the source becomes deliverable again. Otherwise its pending bit is cleared.
- R9: An end-of-interrupt for an edge source pulses eoi_err high for exactly one cycle and changes no state.
- R10: A deliverable bit is pending AND enabled AND NOT queued, and any_pend is the OR of the deliverable vector. An enable write that removes a source's enable also clears its queued mark.
- R11: Every update shows at the outputs in the cycle after the input cycle, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_edge | input | N_SRC | Trigger type per source: 1 = edge, 0 = level |
| line_valid | input | 1 | Line level update strobe |
| line_idx | input | IDX_W | Source index for the line update |
| line_lvl | input | 1 | New line level |
| setp_wr | input | 1 | Set-pending write strobe |
| setp_data | input | N_SRC | Set-pending mask |
| clrp_wr | input | 1 | Clear-pending write strobe |
| clrp_data | input | N_SRC | Clear-pending mask |
| en_wr | input | 1 | Enable vector write strobe |
| en_data | input | N_SRC | New enable vector |
| q_valid | input | 1 | CPU accepts an interrupt into a slot |
| q_idx | input | IDX_W | Index of the accepted source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_idx | input | IDX_W | Index of the completed source |
| pend_rd | output | N_SRC | Pending vector readback |
| dlv | output | N_SRC | Deliverable vector |
| any_pend | output | 1 | At least one source is deliverable |
| eoi_err | output | 1 | One-cycle strobe: end-of-interrupt on an edge source |

## Verification
Some internal bits never reach a port directly: the queued mark, the software-forced bit and the stored line level. A wrong value in one of them shows only later, when a follow-up operation behaves wrongly. A queued mark that is lost shows as a level source that is deliverable again right after its accept. A soft bit that is stuck shows as a pending bit that survives a line fall or a clear write, one cycle after that operation. A stored level that is wrong shows as a pending bit that comes back, or fails to come back, after a clear or a completion. The bench therefore runs each such bit through a two- or three-step sequence. It reads pend_rd and dlv one cycle after each step.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;
  localparam int unsigned SGI_COUNT = 16;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_trk_pkg::*;
#(
  parameter bit SW_LOCK = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  trig_e trig,
  input  logic line_hit,
  input  logic line_lvl,
  input  logic set_hit,
  input  logic clr_hit,
  input  logic acc_hit,
  input  logic eoi_hit,
  input  logic en_wr,
  input  logic en_val,
  output logic pend_o,
  output logic dlv_o,
  output logic dlv_nxt_o
);
  logic lvl_q, pend_q, soft_q, qd_q, en_q;
  logic lvl_n, pend_n, soft_n, qd_n, en_n;

  always_comb begin
    lvl_n  = lvl_q;
    pend_n = pend_q;
    soft_n = soft_q;
    qd_n   = qd_q;
    en_n   = en_q;
    // hardware line
    if (line_hit) begin
      if (trig == TRIG_EDGE) begin
        if (line_lvl && !pend_n) pend_n = 1'b1;
      end else if (line_lvl != lvl_n) begin
        lvl_n = line_lvl;
        if (line_lvl) pend_n = 1'b1;
        else if (!soft_n) pend_n = 1'b0;
      end
    end
    // software mask writes
    if (set_hit && !SW_LOCK) begin
      pend_n = 1'b1;
      if (trig == TRIG_LEVEL) soft_n = 1'b1;
    end
    if (clr_hit && !SW_LOCK) begin
      soft_n = 1'b0;
      pend_n = (trig == TRIG_LEVEL) && lvl_n;
    end
    // CPU takes the interrupt
    if (acc_hit && dlv_o) begin
      if (trig == TRIG_EDGE) pend_n = 1'b0;
      else                   qd_n   = 1'b1;
    end
    // completion, level sources only
    if (eoi_hit && trig == TRIG_LEVEL) begin
      qd_n   = 1'b0;
      soft_n = 1'b0;
      if (!lvl_n) pend_n = 1'b0;
    end
    if (en_wr) begin
      en_n = en_val;
      if (!en_val) qd_n = 1'b0;
    end
  end

  assign dlv_nxt_o = pend_n && en_n && !qd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
      soft_q <= 1'b0;
      qd_q   <= 1'b0;
      en_q   <= 1'b0;
      dlv_o  <= 1'b0;
    end else begin
      lvl_q  <= lvl_n;
      pend_q <= pend_n;
      soft_q <= soft_n;
      qd_q   <= qd_n;
      en_q   <= en_n;
      dlv_o  <= dlv_nxt_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] dlv_nxt,
  input  logic             eoi_on_edge,
  output logic             any_o,
  output logic             err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      any_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      any_o <= |dlv_nxt;
      err_o <= eoi_on_edge;
    end
  end
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_trk_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned BANK_SEL = 0,
  localparam int unsigned IDX_W   = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cfg_edge,
  input  logic             line_valid,
  input  logic [IDX_W-1:0] line_idx,
  input  logic             line_lvl,
  input  logic             setp_wr,
  input  logic [N_SRC-1:0] setp_data,
  input  logic             clrp_wr,
  input  logic [N_SRC-1:0] clrp_data,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_data,
  input  logic             q_valid,
  input  logic [IDX_W-1:0] q_idx,
  input  logic             eoi_valid,
  input  logic [IDX_W-1:0] eoi_idx,
  output logic [N_SRC-1:0] pend_rd,
  output logic [N_SRC-1:0] dlv,
  output logic             any_pend,
  output logic             eoi_err
);
  logic [N_SRC-1:0] dlv_nxt;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam bit LOCK = (BANK_SEL == 0) && (i < SGI_COUNT);
    irq_src_cell #(.SW_LOCK(LOCK)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .trig     (cfg_edge[i] ? TRIG_EDGE : TRIG_LEVEL),
      .line_hit (line_valid && (line_idx == IDX_W'(i))),
      .line_lvl (line_lvl),
      .set_hit  (setp_wr && setp_data[i]),
      .clr_hit  (clrp_wr && clrp_data[i]),
      .acc_hit  (q_valid && (q_idx == IDX_W'(i))),
      .eoi_hit  (eoi_valid && (eoi_idx == IDX_W'(i))),
      .en_wr    (en_wr),
      .en_val   (en_data[i]),
      .pend_o   (pend_rd[i]),
      .dlv_o    (dlv[i]),
      .dlv_nxt_o(dlv_nxt[i])
    );
  end

  irq_summary #(.N_SRC(N_SRC)) u_sum (
    .clk        (clk),
    .rst        (rst),
    .dlv_nxt    (dlv_nxt),
    .eoi_on_edge(eoi_valid && cfg_edge[eoi_idx]),
    .any_o      (any_pend),
    .err_o      (eoi_err)
  );
endmodule

// File: rtl/irq_pend_tracker_chk.sv
module irq_pend_tracker_chk #(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned BANK_SEL = 0,
  parameter int unsigned IDX_W    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] cfg_edge,
  input logic             line_valid,
  input logic             setp_wr,
  input logic             clrp_wr,
  input logic             q_valid,
  input logic [IDX_W-1:0] q_idx,
  input logic             eoi_valid,
  input logic [IDX_W-1:0] eoi_idx,
  input logic [N_SRC-1:0] pend_rd,
  input logic [N_SRC-1:0] dlv,
  input logic             any_pend,
  input logic             eoi_err
);
  assert_edge_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (q_valid && cfg_edge[q_idx] && dlv[q_idx] && !setp_wr && !line_valid)
      |=> !pend_rd[$past(q_idx)]);

  assert_level_queue_R7: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !cfg_edge[q_idx] && dlv[q_idx] && !eoi_valid)
      |=> !dlv[$past(q_idx)]);

  assert_eoi_err_R9: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && cfg_edge[eoi_idx]) |=> eoi_err);

  assert_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    !eoi_valid |=> !eoi_err);

  assert_any_R10: assert property (@(posedge clk) disable iff (rst)
    any_pend == (|dlv));

  assert_dlv_pend_R10: assert property (@(posedge clk) disable iff (rst)
    (dlv & ~pend_rd) == '0);

  if (BANK_SEL == 0) begin : g_sgi
    assert_sgi_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!line_valid && !q_valid && !eoi_valid)
        |=> pend_rd[15:0] == $past(pend_rd[15:0]));
  end
endmodule

bind irq_pend_tracker irq_pend_tracker_chk #(
  .N_SRC(N_SRC), .BANK_SEL(BANK_SEL), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_edge(cfg_edge), .line_valid(line_valid),
  .setp_wr(setp_wr), .clrp_wr(clrp_wr), .q_valid(q_valid), .q_idx(q_idx),
  .eoi_valid(eoi_valid), .eoi_idx(eoi_idx), .pend_rd(pend_rd), .dlv(dlv),
  .any_pend(any_pend), .eoi_err(eoi_err)
);

// File: tb/sim_irq_pend_tracker.sv
module sim_irq_pend_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cfg_edge = 32'h0300_FFFF;
  logic line_valid = 0, line_lvl = 0, setp_wr = 0, clrp_wr = 0, en_wr = 0;
  logic q_valid = 0, eoi_valid = 0;
  logic [IW-1:0] line_idx = '0, q_idx = '0, eoi_idx = '0;
  logic [N-1:0] setp_data = '0, clrp_data = '0, en_data = '0;
  logic [N-1:0] pend_rd, dlv;
  logic any_pend, eoi_err;

  irq_pend_tracker #(.N_SRC(N), .BANK_SEL(0)) u0 (
    .clk(clk), .rst(rst), .cfg_edge(cfg_edge),
    .line_valid(line_valid), .line_idx(line_idx), .line_lvl(line_lvl),
    .setp_wr(setp_wr), .setp_data(setp_data),
    .clrp_wr(clrp_wr), .clrp_data(clrp_data),
    .en_wr(en_wr), .en_data(en_data),
    .q_valid(q_valid), .q_idx(q_idx),
    .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
    .pend_rd(pend_rd), .dlv(dlv), .any_pend(any_pend), .eoi_err(eoi_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    logic [N-1:0] pmask, pexp, dmask, dexp;
    logic        chk_err, err_exp, chk_any, any_exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare results a quarter period after the edge that produced them
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      if (it.due != cyc) check({it.tag, " late"}, 32'(it.due), 32'(cyc));
      check({it.tag, " pend"}, pend_rd & it.pmask, it.pexp & it.pmask);
      check({it.tag, " dlv"}, dlv & it.dmask, it.dexp & it.dmask);
      if (it.chk_err) check({it.tag, " err"}, 32'(eoi_err), 32'(it.err_exp));
      if (it.chk_any) check({it.tag, " any"}, 32'(any_pend), 32'(it.any_exp));
    end
  end

  task automatic expect_at(logic [N-1:0] pm, pe, dm, de,
                           logic ce, ee, ca, ae, string tag);
    item_t it;
    it.due = cyc + 1; it.pmask = pm; it.pexp = pe; it.dmask = dm; it.dexp = de;
    it.chk_err = ce; it.err_exp = ee; it.chk_any = ca; it.any_exp = ae;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    line_valid = 0; setp_wr = 0; clrp_wr = 0; en_wr = 0; q_valid = 0; eoi_valid = 0;
  endtask

  task automatic t_line(int i, logic l);
    @(negedge clk); line_valid = 1; line_idx = IW'(i); line_lvl = l;
  endtask
  task automatic t_setp(logic [N-1:0] d);
    @(negedge clk); setp_wr = 1; setp_data = d;
  endtask
  task automatic t_clrp(logic [N-1:0] d);
    @(negedge clk); clrp_wr = 1; clrp_data = d;
  endtask
  task automatic t_en(logic [N-1:0] d);
    @(negedge clk); en_wr = 1; en_data = d;
  endtask
  task automatic t_acc(int i);
    @(negedge clk); q_valid = 1; q_idx = IW'(i);
  endtask
  task automatic t_eoi(int i);
    @(negedge clk); eoi_valid = 1; eoi_idx = IW'(i);
  endtask

  localparam logic [N-1:0] B3 = 32'h1 << 3, B20 = 32'h1 << 20, B21 = 32'h1 << 21;
  localparam logic [N-1:0] B24 = 32'h1 << 24, B25 = 32'h1 << 25, ALL = '1;

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog actual=timeout expected=completion");
          $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 pend", pend_rd, '0);
    check("R1 dlv", dlv, '0);
    check("R1 any/err", {30'b0, any_pend, eoi_err}, '0);

    t_en(ALL); expect_at(ALL, '0, ALL, '0, 1, 0, 1, 0, "R10 enable only"); idle();
    // level source 20
    t_line(20, 1); expect_at(B20, B20, B20, B20, 0, 0, 1, 1, "R11 R2 level rise"); idle();
    t_line(20, 1); expect_at(B20, B20, B20, B20, 0, 0, 0, 0, "R2 repeat level"); idle();
    t_acc(20); expect_at(B20, B20, B20, '0, 0, 0, 1, 0, "R7 level queued"); idle();
    t_line(20, 0); expect_at(B20, '0, B20, '0, 0, 0, 0, 0, "R2 level fall"); idle();
    t_line(20, 1); expect_at(B20, B20, B20, '0, 0, 0, 0, 0, "R7 queued blocks"); idle();
    t_eoi(20); expect_at(B20, B20, B20, B20, 1, 0, 0, 0, "R8 eoi line high"); idle();
    t_acc(20); expect_at(B20, B20, B20, '0, 0, 0, 0, 0, "R7 requeue"); idle();
    t_line(20, 0); expect_at(B20, '0, B20, '0, 0, 0, 0, 0, "R2 fall queued"); idle();
    t_eoi(20); expect_at(B20, '0, B20, '0, 1, 0, 1, 0, "R8 eoi line low"); idle();
    // soft pending on level source 21
    t_setp(B21); expect_at(B21, B21, B21, B21, 0, 0, 0, 0, "R4 set level"); idle();
    t_line(21, 1); idle();
    t_line(21, 0); expect_at(B21, B21, B21, B21, 0, 0, 0, 0, "R4 R2 soft holds"); idle();
    t_clrp(B21); expect_at(B21, '0, B21, '0, 0, 0, 0, 0, "R5 clear low"); idle();
    t_line(21, 1); idle();
    t_clrp(B21); expect_at(B21, B21, B21, B21, 0, 0, 0, 0, "R5 clear line high"); idle();
    t_line(21, 0); expect_at(B21, '0, B21, '0, 0, 0, 0, 0, "R5 soft cleared"); idle();
    // edge source 24
    t_line(24, 1); expect_at(B24, B24, B24, B24, 0, 0, 0, 0, "R3 edge rise"); idle();
    t_acc(24); expect_at(B24, '0, B24, '0, 0, 0, 0, 0, "R7 edge accept"); idle();
    t_line(24, 1); expect_at(B24, B24, B24, B24, 0, 0, 0, 0, "R3 edge again"); idle();
    t_line(24, 0); expect_at(B24, B24, B24, B24, 0, 0, 0, 0, "R3 edge low ignored"); idle();
    t_eoi(24); expect_at(B24, B24, B24, B24, 1, 1, 0, 0, "R9 eoi edge"); idle();
    @(negedge clk); expect_at('0, '0, '0, '0, 1, 0, 0, 0, "R9 strobe ends");
    // SGI and edge set-pending
    t_setp(B3 | B25); expect_at(B3 | B25, B25, B3 | B25, B25, 0, 0, 0, 0, "R6 R4 set"); idle();
    t_line(3, 1); expect_at(B3, B3, B3, B3, 0, 0, 0, 0, "R6 sgi line"); idle();
    t_clrp(B3); expect_at(B3, B3, B3, B3, 0, 0, 0, 0, "R6 sgi clear"); idle();
    t_clrp(B25); expect_at(B25, '0, B25, '0, 0, 0, 0, 0, "R5 edge clear"); idle();
    // enable removal clears queued
    t_setp(B21); idle();
    t_acc(21); expect_at(B21, B21, B21, '0, 0, 0, 0, 0, "R7 queue 21"); idle();
    t_en(ALL & ~B21); expect_at(B21, B21, B21, '0, 0, 0, 0, 0, "R10 disable"); idle();
    t_en(ALL); expect_at(B21, B21, B21, B21, 0, 0, 1, 1, "R10 queued dropped"); idle();

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(sb.size()), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule